// File: doc/BRIEF.md
# Event State Buffer Source Controller

This block holds the two-bit pending/queued state of one interrupt source and changes it only through the address and direction of memory accesses to the source's pages. The value of the data does not select the operation. Loads on the management page return the state from before the access, and they also change that state as a side effect: they can end the interrupt, unmask the source or mask it. A store to the trigger page fires the source whatever data it carries.

When a trigger is accepted while the source is idle, the block raises a one-cycle notify pulse toward the event queue logic. A level-sensitive input line can also fire the source. This line fires it again after an end-of-interrupt, as long as the line is still asserted.

Software uses the returned state to recover lost events. An unmask load that reports the queued bit set tells software to write the trigger page once, so that the held-back event is replayed. Queue routing and the choice of target are outside this block.

Top module: `esb_source_ctrl`

## Requirements
- R1: After reset the state is 01 (masked). `notify` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A load (acc_valid=1, acc_write=0) raises `rd_valid` for one cycle after the access edge. On that cycle `rd_data` bit 1 holds P and bit 0 holds Q from before the access, and all upper bits are 0. When there is no load, `rd_valid` and `rd_data` are 0.
- R3: A load on the management page (acc_trig_page=0) whose operation code is 0xC sets the state to 00.
- R4: A load on the management page whose operation code is 0xD sets the state to 01, which masks the source.
- R5: A store to the trigger page (acc_trig_page=1) at any offset and with any data is a trigger. The state changes 00→10 with notify, 10→11, 11→11 and 01→01, and only the move out of 00 notifies.
- R6: An end-of-interrupt is either a management-page load with operation code 0x0 or a management-page store with operation code 0x4. It changes 10→00, and 11→10 with notify. States 00 and 01 are left unchanged.
- R7: Whenever the state after the cycle's access would be 00 and `level_line` is 1, the source fires: the state becomes 10 and notify is raised. This re-fires the source after an end-of-interrupt or an unmask while the line is held.
- R8: The following accesses leave the state unchanged and do not notify: management-page stores with any code other than 0x4, management-page loads with codes other than 0x0, 0xC and 0xD, and trigger-page loads.
- R9: If a 0xC load returns Q=1, a following trigger store replays the event and notifies.
- R10: `notify` is registered. It is high for exactly the one cycle after the edge that accepted the firing event.

The operation code is acc_offset[ADDR_W-1:OP_LSB], bits 11:8 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_trig_page | input | 1 | 1 = trigger page, 0 = management page |
| acc_offset | input | ADDR_W | Byte offset within the page |
| acc_wdata | input | DATA_W | Store data (ignored) |
| level_line | input | 1 | Level-sensitive request line |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | DATA_W | Prior P (bit 1) and Q (bit 0) |
| notify | output | 1 | Forwarded-event pulse |

## Verification
A wrong state is not visible at the ports right away. It shows up at the next load, which returns wrong P/Q bits, or at the next trigger or end-of-interrupt, which gives a missing or extra notify pulse. Either effect appears one cycle after that access. For this reason the random stimulus interleaves loads densely with triggers, end-of-interrupt operations and level-line activity, so that a corrupted state is read back within a few cycles. Directed cases cover the masked reset, the 11→10 re-notify, replay after an unmask and re-firing by the level line.

// File: rtl/esb_source_ctrl.sv
module esb_source_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 64,
  parameter int OP_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_trig_page,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              level_line,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              notify
);
  localparam int OP_W = ADDR_W - OP_LSB;
  localparam logic [OP_W-1:0] OP_LD_EOI = OP_W'(4'h0);
  localparam logic [OP_W-1:0] OP_ST_EOI = OP_W'(4'h4);
  localparam logic [OP_W-1:0] OP_SET00  = OP_W'(4'hC);
  localparam logic [OP_W-1:0] OP_SET01  = OP_W'(4'hD);

  logic [1:0]      pq, pq_nx;
  logic            fire_nx;
  logic            is_load, is_trig, is_eoi;
  logic [OP_W-1:0] op;
  logic            unused_bits;

  assign op      = acc_offset[ADDR_W-1:OP_LSB];
  assign is_load = acc_valid && !acc_write;
  assign is_trig = acc_valid && acc_write && acc_trig_page;
  assign is_eoi  = acc_valid && !acc_trig_page &&
                   ((acc_write && op == OP_ST_EOI) || (!acc_write && op == OP_LD_EOI));
  assign unused_bits = ^{acc_wdata, acc_offset[OP_LSB-1:0]};

  always_comb begin
    pq_nx   = pq;
    fire_nx = 1'b0;
    if (is_trig) begin
      case (pq)
        2'b00:   begin pq_nx = 2'b10; fire_nx = 1'b1; end
        2'b10,
        2'b11:   pq_nx = 2'b11;
        default: pq_nx = pq;
      endcase
    end else if (is_eoi) begin
      case (pq)
        2'b10:   pq_nx = 2'b00;
        2'b11:   begin pq_nx = 2'b10; fire_nx = 1'b1; end
        default: pq_nx = pq;
      endcase
    end else if (is_load && !acc_trig_page) begin
      if (op == OP_SET00)      pq_nx = 2'b00;
      else if (op == OP_SET01) pq_nx = 2'b01;
    end
    if (level_line && pq_nx == 2'b00) begin
      pq_nx   = 2'b10;
      fire_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq       <= 2'b01;
      notify   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pq       <= pq_nx;
      notify   <= fire_nx;
      rd_valid <= is_load;
      rd_data  <= is_load ? {{(DATA_W-2){1'b0}}, pq} : '0;
    end
  end

  a_r2_load_returns_prior: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> (rd_valid && rd_data[1:0] == $past(pq)));
  a_r5_trigger_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_trig_page && pq == 2'b00) |=> (notify && pq == 2'b10));
  a_r4_masked_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pq == 2'b01 && !(acc_valid && !acc_write && !acc_trig_page && op == OP_SET00))
      |=> (!notify && pq == 2'b01));
  a_r6_eoi_requeues: assert property (@(posedge clk) disable iff (!rst_n)
    (is_eoi && pq == 2'b11) |=> (notify && pq == 2'b10));
  a_r10_notify_sets_p: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> pq[1]);
  a_r7_level_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (level_line && pq == 2'b00) |=> pq != 2'b00);
endmodule

// File: tb/sim_esb_source_ctrl.sv
module sim_esb_source_ctrl;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_trig_page = 1'b0, level_line = 1'b0;
  logic [ADDR_W-1:0] acc_offset = '0;
  logic [DATA_W-1:0] acc_wdata = '0;
  logic rd_valid, notify;
  logic [DATA_W-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [1:0] m_pq;

  always #2 clk = ~clk;

  esb_source_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_trig_page(acc_trig_page), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .level_line(level_line), .rd_valid(rd_valid), .rd_data(rd_data), .notify(notify));

  function automatic logic [2:0] model(logic [1:0] s, logic v, logic w, logic tp,
                                       logic [3:0] op, logic line);
    logic [1:0] n = s;
    logic f = 1'b0;
    if (v && w && tp) begin
      if (s == 2'b00) begin n = 2'b10; f = 1'b1; end
      else if (s[1]) n = 2'b11;
    end else if (v && !tp && ((w && op == 4'h4) || (!w && op == 4'h0))) begin
      if (s == 2'b10) n = 2'b00;
      else if (s == 2'b11) begin n = 2'b10; f = 1'b1; end
    end else if (v && !w && !tp) begin
      if (op == 4'hC) n = 2'b00;
      else if (op == 4'hD) n = 2'b01;
    end
    if (line && n == 2'b00) begin n = 2'b10; f = 1'b1; end
    return {f, n};
  endfunction

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic w, logic tp, logic [3:0] op, logic line);
    logic [2:0] r;
    logic [1:0] prior = m_pq;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_trig_page = tp; level_line = line;
    acc_offset = {op, 8'($urandom)};
    acc_wdata = {$urandom, $urandom};
    r = model(m_pq, v, w, tp, op, line);
    m_pq = r[1:0];
    @(posedge clk); #1;
    chk({tag, " notify"}, DATA_W'(notify), DATA_W'(r[2]));
    chk({tag, " rd_valid"}, DATA_W'(rd_valid), DATA_W'(v && !w));
    chk({tag, " rd_data"}, rd_data, (v && !w) ? DATA_W'(prior) : '0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_pq = 2'b01;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 notify", DATA_W'(notify), '0);
    chk("R1 rd_valid", DATA_W'(rd_valid), '0);
    @(negedge clk); rst_n = 1'b1;
    step("R1 masked reset read", 1, 0, 0, 4'h8, 0);
    step("R5 trigger while masked", 1, 1, 1, 4'h3, 0);
    step("R3 unmask", 1, 0, 0, 4'hC, 0);
    step("R5 trigger idle", 1, 1, 1, 4'h0, 0);
    step("R5 trigger pending", 1, 1, 1, 4'h7, 0);
    step("R6 load eoi 11", 1, 0, 0, 4'h0, 0);
    step("R6 load eoi 10", 1, 0, 0, 4'h0, 0);
    step("R6 store eoi idle", 1, 1, 0, 4'h4, 0);
    step("R8 other store", 1, 1, 0, 4'h8, 0);
    step("R8 trig page load", 1, 0, 1, 4'hC, 0);
    step("R4 mask", 1, 0, 0, 4'hD, 0);
    step("R4 trigger masked", 1, 1, 1, 4'h1, 0);
    step("R3 unmask again", 1, 0, 0, 4'hC, 0);
    step("R9 trigger", 1, 1, 1, 4'h0, 0);
    step("R9 trigger queued", 1, 1, 1, 4'h0, 0);
    step("R9 unmask sees Q", 1, 0, 0, 4'hC, 0);
    step("R9 replay", 1, 1, 1, 4'h0, 0);
    step("R6 store eoi", 1, 1, 0, 4'h4, 0);
    step("R7 line rises", 0, 0, 0, 4'h0, 1);
    step("R7 line held", 0, 0, 0, 4'h0, 1);
    step("R7 eoi refires", 1, 1, 0, 4'h4, 1);
    step("R10 pulse ends", 1, 0, 0, 4'h8, 1);
    step("R4 mask with line", 1, 0, 0, 4'hD, 1);
    step("R4 masked line", 0, 0, 0, 4'h0, 1);
    step("R7 unmask refires", 1, 0, 0, 4'hC, 1);
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      case ($urandom % 5)
        0: op = 4'h0; 1: op = 4'h4; 2: op = 4'hC; 3: op = 4'hD;
        default: op = 4'($urandom);
      endcase
      step("R2 R10 random", ($urandom % 4) != 0, $urandom % 2, ($urandom % 3) == 0,
           op, ($urandom % 6) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule